// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block gathers eight interrupt request lines and chooses the most urgent one. It raises a single interrupt output toward a processor and returns a vector byte when the processor acknowledges. It keeps three 8-bit registers: pending requests, a mask, and the lines currently being serviced. Priority is circular. A rotation base names the line that currently ranks highest, and the rank falls with each step around the ring from that line.

Software uses a byte-wide port with two addresses and single-cycle read and write strobes. Address 0 takes commands: start of initialization, end-of-interrupt and rotation codes, read select, poll and special mask. Address 1 carries the initialization words, and after that it carries the mask. A separate trigger-select port chooses edge or level sensing for each line. It is filtered by a build-time constant, and an initialization command does not clear it. The register port is a plain strobe interface. There is no valid/ready handshake and no back-pressure: every strobed access completes in the cycle it is presented.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, the request, mask and in-service registers read as zero, the trigger-select register reads zero, and the interrupt output is low.
- R2: Initialization starts with a write to address 0 that has bit 4 set.
  - It clears mask, in-service, rotation base, vector base and all modes, and clears edge-latched requests. It leaves trigger-select alone.
  - Bit 0 says whether a mode word will follow. Bit 1 says the controller runs alone.
  - The next word on address 1 stores the vector base as data AND 0xF8. A word for cascade setup is taken next only when bit 1 was 0. The mode word is taken last, only when bit 0 was 1.
  - The interrupt output is low on the cycle after the initialization write.
- R3: Outside initialization, a write to address 1 loads the mask, and a read of address 1 returns it. A masked line never raises the interrupt output.
- R4: On an edge-sensed line (trigger-select bit 0), a request latches on a rising input only. An acknowledge of that line clears it.
- R5: On a level-sensed line (trigger-select bit 1), the request bit follows the input, and an acknowledge does not clear it. A trigger-select write stores the data AND the constant TRIG_MASK (default 0xF8).
- R6: The rank of line i is (i - base) mod 8. Rank 0 is the most urgent. The interrupt output goes high one cycle after an unmasked request outranks every in-service line.
- R7: While the output is asserted, the acknowledge vector is the vector base OR the granted line number. Acknowledging then sets that line's in-service bit. With nothing grantable, the vector uses line 7 and no state changes.
- R8: When the mode word bit 1 enables automatic end-of-interrupt, an acknowledge does not set the in-service bit. If rotate-on-auto-EOI is on (command code 4 sets it, code 0 clears it), the base becomes line+1.
- R9: Address 0 writes with bits 4 and 3 clear decode bits 7:5 as follows:
  - 1 clears the most urgent in-service bit.
  - 5 does the same and also sets the base to that line+1.
  - 3 clears the in-service bit of line bits 2:0.
  - 6 sets the base to bits 2:0 plus 1.
  - 7 clears the in-service bit of line bits 2:0 and sets the base to that line+1.
  - 2 does nothing.
- R10: A write to address 0 with bit 4 clear, bit 3 set and bit 1 set selects what address 0 reads: bit 0 = 1 gives in-service, bit 0 = 0 gives request.
- R11: Setting bit 2 of that command arms poll. The next read then returns the grantable line number (7 if none), clears that line's request and in-service bits, and disarms poll.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for poll side effects) |
| reg_addr | input | 1 | Register address, 0 = command, 1 = data/mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| trig_wr | input | 1 | Trigger-select write strobe |
| trig_wdata | input | 8 | Trigger-select write data |
| trig_rdata | output | 8 | Trigger-select register value |
| irq_lines | input | 8 | Interrupt request inputs |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| int_vector | output | 8 | Vector for the line granted at acknowledge |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench goes after nesting: a lower-ranked request must stay blocked while a higher-ranked line is in service. A resolver that ignored in-service state would assert the output early and return the wrong vector. It also walks the base through explicit, rotating-EOI and auto-EOI rotation, where an off-by-one base would grant the wrong line. Other cases are level lines surviving an acknowledge, poll reads that clear state, and spurious acknowledges returning line 7. Initialization is checked along both the single and cascade word paths, and across it the trigger-select value must persist while the output drops for one cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int N_LINES = 8;
  localparam int LINE_W  = $clog2(N_LINES);

  typedef logic [N_LINES-1:0] line_vec_t;
  typedef logic [LINE_W-1:0]  line_idx_t;

  typedef enum logic [1:0] {
    INIT_IDLE  = 2'd0,
    INIT_VBASE = 2'd1,
    INIT_CASC  = 2'd2,
    INIT_MODE  = 2'd3
  } init_st_t;

  typedef enum logic [2:0] {
    OP_ROT_AEOI_CLR = 3'd0,
    OP_EOI_NS       = 3'd1,
    OP_NOP          = 3'd2,
    OP_EOI_SPEC     = 3'd3,
    OP_ROT_AEOI_SET = 3'd4,
    OP_EOI_NS_ROT   = 3'd5,
    OP_SET_BASE     = 3'd6,
    OP_EOI_SPEC_ROT = 3'd7
  } cmd_op_t;
endpackage

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] base_i,
  output logic         found_o,
  output logic [W-1:0] line_o,
  output logic [W-1:0] rank_o
);
  // Scan from the least urgent rank down so the most urgent hit is kept.
  always_comb begin
    logic [W-1:0] idx;
    found_o = 1'b0;
    line_o  = '0;
    rank_o  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = base_i + W'(k);
      if (vec_i[idx]) begin
        found_o = 1'b1;
        line_o  = idx;
        rank_o  = W'(k);
      end
    end
  end
endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] last_q;
  logic [N-1:0] rise;

  assign rise = lines_i & ~last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      irr_o  <= '0;
    end else begin
      last_q <= lines_i;
      irr_o  <= (level_i & lines_i) | (~level_i & (rise | (irr_o & ~clr_i)));
    end
  end

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr_o & $past(level_i)) == ($past(lines_i) & $past(level_i)))); // R5

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((irr_o ^ $past(irr_o)) & ~$past(level_i) & ~$past(rise) & ~$past(clr_i)) == '0)); // R4
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irqc_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK   = 8'hF8,
  parameter int         NESTED_LINE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       trig_wr,
  input  logic [7:0] trig_wdata,
  output logic [7:0] trig_rdata,
  input  logic [7:0] irq_lines,
  input  logic       int_ack,
  output logic [7:0] int_vector,
  output logic       irq_out
);
  localparam int VB_W = 8 - LINE_W;
  localparam line_idx_t SPUR_LINE = line_idx_t'(N_LINES - 1);

  line_vec_t imr_q, isr_q, irr, trig_q, latch_clr, cur_vec;
  line_idx_t base_q;
  logic [VB_W-1:0] vbase_q;
  init_st_t  ist_q;
  logic rr_isr_q, poll_q, smm_q, aeoi_q, rot_aeoi_q, sfnm_q, need4_q, single_q, irq_q;

  logic      pend_found, cur_found, eoi_found, grant, ack_ok, poll_rd;
  line_idx_t pend_line, pend_rank, cur_line, cur_rank, eoi_line, eoi_rank, grant_line;

  logic wr0, wr1, init_cmd, ocw3_cmd, ocw2_cmd;
  cmd_op_t op;

  assign wr0      = reg_wr & ~reg_addr;
  assign wr1      = reg_wr & reg_addr;
  assign init_cmd = wr0 & reg_wdata[4];
  assign ocw3_cmd = wr0 & ~reg_wdata[4] & reg_wdata[3];
  assign ocw2_cmd = wr0 & ~reg_wdata[4] & ~reg_wdata[3];
  assign op       = cmd_op_t'(reg_wdata[7:5]);

  // Current-priority view: special mask hides masked lines, nested mode hides the cascade line.
  always_comb begin
    cur_vec = isr_q;
    if (smm_q)  cur_vec = cur_vec & ~imr_q;
    if (sfnm_q) cur_vec[NESTED_LINE] = 1'b0;
  end

  irqc_resolver #(.N(N_LINES), .W(LINE_W)) u_pend (
    .vec_i(irr & ~imr_q), .base_i(base_q),
    .found_o(pend_found), .line_o(pend_line), .rank_o(pend_rank));

  irqc_resolver #(.N(N_LINES), .W(LINE_W)) u_cur (
    .vec_i(cur_vec), .base_i(base_q),
    .found_o(cur_found), .line_o(cur_line), .rank_o(cur_rank));

  irqc_resolver #(.N(N_LINES), .W(LINE_W)) u_eoi (
    .vec_i(isr_q), .base_i(base_q),
    .found_o(eoi_found), .line_o(eoi_line), .rank_o(eoi_rank));

  assign grant      = pend_found & (!cur_found || (pend_rank < cur_rank));
  assign grant_line = grant ? pend_line : SPUR_LINE;
  assign ack_ok     = int_ack & grant;
  assign poll_rd    = reg_rd & poll_q;

  assign int_vector = {vbase_q, grant_line};
  assign irq_out    = irq_q;
  assign trig_rdata = trig_q;

  always_comb begin
    if (poll_q)         reg_rdata = {{VB_W{1'b0}}, grant_line};
    else if (reg_addr)  reg_rdata = imr_q;
    else if (rr_isr_q)  reg_rdata = isr_q;
    else                reg_rdata = irr;
  end

  always_comb begin
    latch_clr = '0;
    if (init_cmd) latch_clr = '1;
    else begin
      if (ack_ok)             latch_clr = latch_clr | ((line_vec_t'(1) << pend_line) & ~trig_q);
      if (poll_rd && grant)   latch_clr = latch_clr | (line_vec_t'(1) << pend_line);
    end
  end

  irqc_req_latch #(.N(N_LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_lines), .level_i(trig_q),
    .clr_i(latch_clr), .irr_o(irr));

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= '0;
    else if (trig_wr) trig_q <= trig_wdata & TRIG_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr_q <= '0; isr_q <= '0; base_q <= '0; vbase_q <= '0;
      ist_q <= INIT_IDLE; rr_isr_q <= 1'b0; poll_q <= 1'b0; smm_q <= 1'b0;
      aeoi_q <= 1'b0; rot_aeoi_q <= 1'b0; sfnm_q <= 1'b0; need4_q <= 1'b0;
      single_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= init_cmd ? 1'b0 : grant;

      if (ack_ok) begin
        if (aeoi_q) begin
          if (rot_aeoi_q) base_q <= pend_line + 1'b1;
        end else begin
          isr_q[pend_line] <= 1'b1;
        end
      end

      if (poll_rd) begin
        poll_q <= 1'b0;
        if (grant) isr_q[pend_line] <= 1'b0;
      end

      if (init_cmd) begin
        imr_q <= '0; isr_q <= '0; base_q <= '0; vbase_q <= '0;
        rr_isr_q <= 1'b0; poll_q <= 1'b0; smm_q <= 1'b0; aeoi_q <= 1'b0;
        rot_aeoi_q <= 1'b0; sfnm_q <= 1'b0;
        need4_q  <= reg_wdata[0];
        single_q <= reg_wdata[1];
        ist_q    <= INIT_VBASE;
      end else if (ocw3_cmd) begin
        if (reg_wdata[2]) poll_q <= 1'b1;
        if (reg_wdata[1]) rr_isr_q <= reg_wdata[0];
        if (reg_wdata[6]) smm_q <= reg_wdata[5];
      end else if (ocw2_cmd) begin
        case (op)
          OP_ROT_AEOI_CLR, OP_ROT_AEOI_SET: rot_aeoi_q <= reg_wdata[7];
          OP_EOI_NS, OP_EOI_NS_ROT: begin
            if (eoi_found) begin
              isr_q[eoi_line] <= 1'b0;
              if (op == OP_EOI_NS_ROT) base_q <= eoi_line + 1'b1;
            end
          end
          OP_EOI_SPEC: isr_q[reg_wdata[2:0]] <= 1'b0;
          OP_SET_BASE: base_q <= reg_wdata[2:0] + 1'b1;
          OP_EOI_SPEC_ROT: begin
            isr_q[reg_wdata[2:0]] <= 1'b0;
            base_q <= reg_wdata[2:0] + 1'b1;
          end
          default: ;
        endcase
      end else if (wr1) begin
        case (ist_q)
          INIT_IDLE:  imr_q <= reg_wdata;
          INIT_VBASE: begin
            vbase_q <= reg_wdata[7:LINE_W];
            if (single_q) ist_q <= need4_q ? INIT_MODE : INIT_IDLE;
            else          ist_q <= INIT_CASC;
          end
          INIT_CASC: ist_q <= need4_q ? INIT_MODE : INIT_IDLE;
          INIT_MODE: begin
            sfnm_q <= reg_wdata[4];
            aeoi_q <= reg_wdata[1];
            ist_q  <= INIT_IDLE;
          end
          default: ist_q <= INIT_IDLE;
        endcase
      end
    end
  end

  AST_INIT_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> !irq_out); // R2

  AST_TRIG_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> trig_rdata == ($past(trig_wdata) & TRIG_MASK)); // R5

  AST_ACK_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && !aeoi_q && !reg_wr && !reg_rd) |=> isr_q[$past(pend_line)]); // R7

  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && aeoi_q && !reg_wr && !reg_rd) |=> $stable(isr_q)); // R8

  AST_POLL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !reg_wr) |=> !poll_q); // R11

  AST_EOI_TOP_RANK: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_found && cur_found) |-> (eoi_rank <= cur_rank)); // R9

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !$past(init_cmd)) |-> $past(pend_found)); // R6
endmodule

// File: tb/tb_irq_ctrl8.sv
module tb_irq_ctrl8;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 68;

  localparam logic [3:0] O_WR = 4'd0, O_RD = 4'd1, O_ACK = 4'd2, O_SET = 4'd3,
                         O_TW = 4'd4, O_TR = 4'd5, O_IRQ = 4'd6;

  // Entry: {op, addr, data, expected, requirement}
  localparam logic [24:0] VEC [NV] = '{
    {O_WR, 1'b0, 8'h13, 8'h00, 4'd2},  // R2 init, single, mode word follows
    {O_WR, 1'b1, 8'h20, 8'h00, 4'd2},  // R2 vector base 0x20
    {O_WR, 1'b1, 8'h00, 8'h00, 4'd2},  // R2 mode word
    {O_RD, 1'b1, 8'h00, 8'h00, 4'd3},  // R3
    {O_WR, 1'b1, 8'hF0, 8'h00, 4'd3},  // R3 mask load
    {O_RD, 1'b1, 8'h00, 8'hF0, 4'd3},  // R3
    {O_SET,1'b0, 8'h24, 8'h00, 4'd4},  // R4 lines 2,5 rise
    {O_RD, 1'b0, 8'h00, 8'h24, 4'd4},  // R4
    {O_IRQ,1'b0, 8'h00, 8'h01, 4'd6},  // R6
    {O_ACK,1'b0, 8'h00, 8'h22, 4'd7},  // R7
    {O_WR, 1'b0, 8'h0B, 8'h00, 4'd10}, // R10 read in-service
    {O_RD, 1'b0, 8'h00, 8'h04, 4'd7},  // R7
    {O_IRQ,1'b0, 8'h00, 8'h00, 4'd3},  // R3 line5 masked
    {O_WR, 1'b1, 8'h00, 8'h00, 4'd3},  // R3
    {O_IRQ,1'b0, 8'h00, 8'h00, 4'd6},  // R6 blocked by line2
    {O_WR, 1'b0, 8'h20, 8'h00, 4'd9},  // R9 non-specific EOI
    {O_IRQ,1'b0, 8'h00, 8'h01, 4'd9},  // R9
    {O_ACK,1'b0, 8'h00, 8'h25, 4'd7},  // R7
    {O_SET,1'b0, 8'h26, 8'h00, 4'd4},  // R4 line1 rises
    {O_IRQ,1'b0, 8'h00, 8'h01, 4'd6},  // R6 line1 outranks line5
    {O_ACK,1'b0, 8'h00, 8'h21, 4'd6},  // R6
    {O_WR, 1'b0, 8'h20, 8'h00, 4'd9},  // R9
    {O_RD, 1'b0, 8'h00, 8'h20, 4'd9},  // R9
    {O_WR, 1'b0, 8'h65, 8'h00, 4'd9},  // R9 specific EOI line5
    {O_RD, 1'b0, 8'h00, 8'h00, 4'd9},  // R9
    {O_WR, 1'b0, 8'hC0, 8'h00, 4'd6},  // R6 base = 1
    {O_SET,1'b0, 8'h00, 8'h00, 4'd4},  // R4
    {O_SET,1'b0, 8'h09, 8'h00, 4'd4},  // R4 lines 0,3
    {O_ACK,1'b0, 8'h00, 8'h23, 4'd6},  // R6 line3 wins
    {O_IRQ,1'b0, 8'h00, 8'h00, 4'd6},  // R6
    {O_WR, 1'b0, 8'hA0, 8'h00, 4'd9},  // R9 rotating EOI
    {O_IRQ,1'b0, 8'h00, 8'h01, 4'd9},  // R9
    {O_RD, 1'b0, 8'h00, 8'h00, 4'd9},  // R9
    {O_ACK,1'b0, 8'h00, 8'h20, 4'd9},  // R9
    {O_WR, 1'b0, 8'hE0, 8'h00, 4'd9},  // R9 specific rotate line0
    {O_RD, 1'b0, 8'h00, 8'h00, 4'd9},  // R9
    {O_ACK,1'b0, 8'h00, 8'h27, 4'd7},  // R7 spurious
    {O_SET,1'b0, 8'h00, 8'h00, 4'd11}, // R11
    {O_SET,1'b0, 8'h40, 8'h00, 4'd11}, // R11
    {O_WR, 1'b0, 8'h0C, 8'h00, 4'd11}, // R11 arm poll
    {O_RD, 1'b0, 8'h00, 8'h06, 4'd11}, // R11
    {O_RD, 1'b0, 8'h00, 8'h00, 4'd11}, // R11 poll disarmed
    {O_WR, 1'b0, 8'h0A, 8'h00, 4'd10}, // R10 read request
    {O_RD, 1'b0, 8'h00, 8'h00, 4'd11}, // R11 request cleared
    {O_IRQ,1'b0, 8'h00, 8'h00, 4'd11}, // R11
    {O_WR, 1'b0, 8'h0C, 8'h00, 4'd11}, // R11
    {O_RD, 1'b0, 8'h00, 8'h07, 4'd11}, // R11 none pending
    {O_SET,1'b0, 8'h00, 8'h00, 4'd5},  // R5
    {O_TW, 1'b0, 8'hFF, 8'h00, 4'd5},  // R5
    {O_TR, 1'b0, 8'h00, 8'hF8, 4'd5},  // R5
    {O_SET,1'b0, 8'h80, 8'h00, 4'd5},  // R5 level line7
    {O_RD, 1'b0, 8'h00, 8'h80, 4'd5},  // R5
    {O_ACK,1'b0, 8'h00, 8'h27, 4'd5},  // R5
    {O_RD, 1'b0, 8'h00, 8'h80, 4'd5},  // R5 survives ack
    {O_SET,1'b0, 8'h00, 8'h00, 4'd5},  // R5
    {O_RD, 1'b0, 8'h00, 8'h00, 4'd5},  // R5 follows input
    {O_WR, 1'b0, 8'h13, 8'h00, 4'd2},  // R2 re-init
    {O_TR, 1'b0, 8'h00, 8'hF8, 4'd2},  // R2 trigger kept
    {O_WR, 1'b1, 8'h30, 8'h00, 4'd2},  // R2
    {O_WR, 1'b1, 8'h02, 8'h00, 4'd8},  // R8 auto EOI
    {O_WR, 1'b0, 8'h80, 8'h00, 4'd8},  // R8 rotate on auto EOI
    {O_SET,1'b0, 8'h10, 8'h00, 4'd8},  // R8
    {O_ACK,1'b0, 8'h00, 8'h34, 4'd8},  // R8
    {O_WR, 1'b0, 8'h0B, 8'h00, 4'd8},  // R8
    {O_RD, 1'b0, 8'h00, 8'h00, 4'd8},  // R8 no in-service
    {O_SET,1'b0, 8'h30, 8'h00, 4'd8},  // R8
    {O_ACK,1'b0, 8'h00, 8'h35, 4'd8},  // R8 base moved to 5
    {O_IRQ,1'b0, 8'h00, 8'h01, 4'd6}   // R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, trig_wdata = '0, irq_lines = '0;
  logic trig_wr = 1'b0, int_ack = 1'b0;
  logic [7:0] reg_rdata, trig_rdata, int_vector;
  logic irq_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl8 dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_wr(trig_wr),
    .trig_wdata(trig_wdata), .trig_rdata(trig_rdata), .irq_lines(irq_lines),
    .int_ack(int_ack), .int_vector(int_vector), .irq_out(irq_out));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int rq);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual 0x%02h expected 0x%02h", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic a, input logic [7:0] d,
                        input logic [7:0] e, input int rq);
    @(negedge clk);
    reg_addr = a;
    case (op)
      O_WR:  begin reg_wr = 1'b1; reg_wdata = d; end
      O_RD:  reg_rd = 1'b1;
      O_ACK: int_ack = 1'b1;
      O_SET: irq_lines = d;
      O_TW:  begin trig_wr = 1'b1; trig_wdata = d; end
      default: ;
    endcase
    #1;
    case (op)
      O_RD:  check(reg_rdata, e, rq);
      O_ACK: check(int_vector, e, rq);
      O_TR:  check(trig_rdata, e, rq);
      O_IRQ: check({7'b0, irq_out}, e, rq);
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; int_ack = 1'b0; trig_wr = 1'b0;
    @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    run_op(O_RD, 1'b0, 8'h00, 8'h00, 1);
    run_op(O_RD, 1'b1, 8'h00, 8'h00, 1);
    run_op(O_IRQ, 1'b0, 8'h00, 8'h00, 1);
    run_op(O_TR, 1'b0, 8'h00, 8'h00, 1);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][24:21], VEC[i][20], VEC[i][19:12], VEC[i][11:4], int'(VEC[i][3:0]));
    end

    // R2: output forced low right after an init write while a request is pending
    @(negedge clk);
    #1 check({7'b0, irq_out}, 8'h01, 6);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h10;
    @(posedge clk);
    #1 check({7'b0, irq_out}, 8'h00, 2);
    @(negedge clk) reg_wr = 1'b0;
    @(posedge clk);
    // R2 cascade path: base word, cascade word, then mask
    run_op(O_WR, 1'b1, 8'h48, 8'h00, 2);
    run_op(O_WR, 1'b1, 8'hAA, 8'h00, 2);
    run_op(O_WR, 1'b1, 8'h0F, 8'h00, 2);
    run_op(O_RD, 1'b1, 8'h00, 8'h0F, 2);
    run_op(O_ACK, 1'b0, 8'h00, 8'h4C, 2);

    finish_run();
  end
endmodule